// File: doc/BRIEF.md
# Byte Transmit Queue for a Serial Framer

This block is a four-entry, byte-wide queue between a processor's register writes and a bit-serial frame transmitter. The processor side writes bytes through a write-only data port. The transmitter side takes bytes from the head of the queue by pulsing a pop strobe. There is no read-back path for queued data. Software must not rely on any value read from the data port, and the bench never checks one.

Status flows back on plain pins. A not-full flag doubles as the write-side ready. A queue interrupt is asserted when the number of free slots reaches a level chosen by a 2-bit code. A sticky underflow flag records every pop taken from an empty queue. Control arrives as single-cycle command pulses: a 1 performs the action once, and a 0 does nothing. An abort indication from the transmitter empties the queue in the same way as the flush command.

The write side follows valid/ready rules, with one difference: a byte is never held. A byte presented with `wr_valid` while `wr_ready` is low is dropped, except when a pop happens in that same cycle. The read side offers `rd_valid` as not-empty. `rd_ready` is an unconditional pop strobe, and a pop while empty is legal and is recorded as an underflow.

Top module: `txq_hdlc_tx`

## Requirements
- R1: After reset the queue is empty: `wr_ready`=1, `rd_valid`=0 and `udr_flag`=0.
- R2: Bytes leave in the order in which they were accepted. `rd_data` shows the oldest byte whenever `rd_valid`=1, and each `rd_ready` pulse removes that byte.
- R3: The queue holds 4 bytes. `wr_ready` is 1 exactly when fewer than 4 are held. A write to a full queue with no pop in the same cycle is dropped, and the contents stay unchanged.
- R4: When the queue is full and a write and a pop happen in the same cycle, the write is accepted and the queue stays full.
- R5: `irq` is 1 when the free-slot count is at least the level that `thr_code` selects. Code 0 needs 4 free slots (empty), code 1 needs 3, code 2 needs 2 and code 3 needs 1.
- R6: A `cmd_flush` pulse empties the queue at the next clock edge and discards every held byte.
- R7: A `tx_abort` pulse empties the queue at the next clock edge, in the same way as R6.
- R8: A pop while `rd_valid`=0 sets `udr_flag` at the next edge. This does not affect `irq` or the queue contents.
- R9: `udr_flag` stays set until a `cmd_clr_udr` pulse. When the clear pulse and an empty pop arrive in the same cycle, the set wins. A 0 on any command input has no effect, and flushes do not clear the flag.
- R10: A flush or abort in the same cycle as a write wins: the queue is empty after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_code | input | 2 | Interrupt free-slot level code |
| cmd_flush | input | 1 | Flush command pulse |
| cmd_clr_udr | input | 1 | Clear-underflow command pulse |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Queue not full |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Oldest queued byte |
| rd_ready | input | 1 | Pop strobe from transmitter |
| tx_abort | input | 1 | Abort from transmitter, flushes queue |
| udr_flag | output | 1 | Sticky underflow status |
| irq | output | 1 | Queue level interrupt |

## Verification
The held-byte count and the underflow flag are registers. A write, pop, flush or abort is therefore seen on `wr_ready`, `rd_valid`, `rd_data`, `irq` and `udr_flag` one clock edge after the cycle in which it was presented. A change of `thr_code` reaches `irq` in the same cycle, with no clock edge, because that path is combinational. The bench drives inputs 1 ns after a rising edge and holds them for one full cycle. It samples results 1 ns after the next rising edge, and samples `irq` for a new code shortly after the code changes.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txq_op_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  txq_op_t       op,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          pop_empty
);
  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop    = op.pop && (cnt_q != '0);
  assign do_push   = op.push && ((cnt_q != CW'(DEPTH)) || do_pop);
  assign pop_empty = op.pop && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || op.flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (do_push && !op.flush && wp_q == PW'(g)) q <= wr_data;
    end
    assign slot[g] = q;
  end

  assign rd_data = slot[rp_q];
  assign count   = cnt_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op.flush |=> (cnt_q == '0));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && op.push && !op.pop && !op.flush)
      |=> (cnt_q == CW'(DEPTH) && $stable(wp_q)));
  p_full_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && op.push && op.pop && !op.flush)
      |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    thr_code,
  output logic          full,
  output logic          empty,
  output logic          irq
);
  logic [CW-1:0] free_slots, need;

  assign free_slots = CW'(DEPTH) - count;
  assign need       = CW'(DEPTH) - CW'(thr_code);
  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign irq        = (free_slots >= need);

  p_empty_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> irq);
  p_full_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !irq);
endmodule

// File: rtl/txq_udr.sv
module txq_udr (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_empty,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (pop_empty) flag_q <= 1'b1;
    else if (clr)       flag_q <= 1'b0;
  end

  assign flag = flag_q;

  p_udr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> flag_q);
  p_udr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/txq_hdlc_tx.sv
module txq_hdlc_tx
  import txq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   thr_code,
  input  logic         cmd_flush,
  input  logic         cmd_clr_udr,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready,
  input  logic         tx_abort,
  output logic         udr_flag,
  output logic         irq
);
  txq_op_t       op;
  logic [CW-1:0] count;
  logic          full, empty, pop_empty;

  assign op.push  = wr_valid;
  assign op.pop   = rd_ready;
  assign op.flush = cmd_flush | tx_abort;

  txq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_data(wr_data),
    .rd_data(rd_data), .count(count), .pop_empty(pop_empty)
  );

  txq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .count(count), .thr_code(thr_code),
    .full(full), .empty(empty), .irq(irq)
  );

  txq_udr u_udr (
    .clk(clk), .rst_n(rst_n), .pop_empty(pop_empty),
    .clr(cmd_clr_udr), .flag(udr_flag)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;

  p_abort_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !rd_valid);
  p_flush_beats_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush && wr_valid) |=> (wr_ready && !rd_valid));
endmodule

// File: tb/txq_hdlc_tx_tb.sv
module txq_hdlc_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] thr_code = 2'd0;
  logic       cmd_flush = 1'b0, cmd_clr_udr = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0, tx_abort = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, rd_valid, udr_flag, irq;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  txq_hdlc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .thr_code(thr_code), .cmd_flush(cmd_flush),
    .cmd_clr_udr(cmd_clr_udr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .tx_abort(tx_abort), .udr_flag(udr_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b; edge1(); wr_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    chk(rd_valid && rd_data == exp, req, int'(rd_data), int'(exp));
    rd_ready = 1'b1; edge1(); rd_ready = 1'b0;
  endtask

  task automatic flush();
    cmd_flush = 1'b1; edge1(); cmd_flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(udr_flag == 1'b0, "R1 udr_flag", int'(udr_flag), 0);
  endtask

  task automatic t_order();
    push(8'hA1); push(8'hB2); push(8'hC3);
    pop_chk(8'hA1, "R2 first"); pop_chk(8'hB2, "R2 second"); pop_chk(8'hC3, "R2 third");
    chk(rd_valid == 1'b0, "R2 drained", int'(rd_valid), 0);
  endtask

  task automatic t_full_drop();
    for (int i = 0; i < 4; i++) push(8'h20 + 8'(i));
    chk(wr_ready == 1'b0, "R3 full", int'(wr_ready), 0);
    push(8'hEE);
    chk(wr_ready == 1'b0, "R3 still full", int'(wr_ready), 0);
    for (int i = 0; i < 4; i++) pop_chk(8'h20 + 8'(i), "R3 kept order no drop-in");
    chk(rd_valid == 1'b0, "R3 dropped byte absent", int'(rd_valid), 0);
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
    chk(rd_data == 8'h10, "R4 head", int'(rd_data), 'h10);
    wr_valid = 1'b1; wr_data = 8'h55; rd_ready = 1'b1; edge1();
    wr_valid = 1'b0; rd_ready = 1'b0;
    chk(wr_ready == 1'b0, "R4 stays full", int'(wr_ready), 0);
    pop_chk(8'h11, "R4 drain"); pop_chk(8'h12, "R4 drain");
    pop_chk(8'h13, "R4 drain"); pop_chk(8'h55, "R4 swapped byte");
  endtask

  task automatic t_irq();
    for (int code = 0; code < 4; code++) begin
      for (int lvl = 0; lvl <= 4; lvl++) begin
        flush();
        for (int k = 0; k < lvl; k++) push(8'(k));
        thr_code = 2'(code); #1;
        chk(irq == ((4 - lvl) >= (4 - code)), "R5 irq level", int'(irq),
            int'((4 - lvl) >= (4 - code)));
      end
    end
    thr_code = 2'd0; flush();
  endtask

  task automatic t_flush();
    push(8'h01); push(8'h02);
    cmd_flush = 1'b1; wr_valid = 1'b1; wr_data = 8'h99; edge1();
    cmd_flush = 1'b0; wr_valid = 1'b0;
    chk(rd_valid == 1'b0, "R10 flush beats write", int'(rd_valid), 0);
    chk(wr_ready == 1'b1, "R6 flushed ready", int'(wr_ready), 1);
    push(8'h77);
    pop_chk(8'h77, "R6 old bytes discarded");
  endtask

  task automatic t_abort();
    push(8'h31); push(8'h32); push(8'h33);
    tx_abort = 1'b1; edge1(); tx_abort = 1'b0;
    chk(rd_valid == 1'b0, "R7 abort empties", int'(rd_valid), 0);
    push(8'h44);
    pop_chk(8'h44, "R7 fresh after abort");
  endtask

  task automatic t_udr();
    thr_code = 2'd3;
    rd_ready = 1'b1; edge1(); rd_ready = 1'b0;
    chk(udr_flag == 1'b1, "R8 set on empty pop", int'(udr_flag), 1);
    chk(irq == 1'b1, "R8 irq unaffected", int'(irq), 1);
    chk(rd_valid == 1'b0, "R8 queue unaffected", int'(rd_valid), 0);
    push(8'h66); pop_chk(8'h66, "R9 traffic"); flush();
    tx_abort = 1'b1; edge1(); tx_abort = 1'b0;
    edge1(); edge1();
    chk(udr_flag == 1'b1, "R9 held without clear", int'(udr_flag), 1);
    cmd_clr_udr = 1'b1; rd_ready = 1'b1; edge1(); cmd_clr_udr = 1'b0; rd_ready = 1'b0;
    chk(udr_flag == 1'b1, "R9 set wins over clear", int'(udr_flag), 1);
    cmd_clr_udr = 1'b1; edge1(); cmd_clr_udr = 1'b0;
    chk(udr_flag == 1'b0, "R9 cleared", int'(udr_flag), 0);
    edge1();
    chk(udr_flag == 1'b0, "R9 stays clear", int'(udr_flag), 0);
    thr_code = 2'd0;
  endtask

  initial begin
    repeat (3) edge1();
    rst_n = 1'b1; edge1();
    t_reset();
    t_order();
    t_full_drop();
    t_full_swap();
    t_irq();
    t_flush();
    t_abort();
    t_udr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule